// File: doc/BRIEF.md
# Guarded Move Transport Network

This block is the transport network of a processor whose only operation is the data move. Each cycle it can take one instruction word holding one move slot per bus. A slot names a source, a destination port and an optional guard. The source is either a 16-bit constant carried in the slot or one of the output ports: register file read ports and function unit result ports. The destination is one of the input ports: register file write ports and function unit operand or trigger ports. All buses carry their moves in the same cycle. The function units and register file sit outside the block and are seen only as ports. Their output values come in on a flat data vector, and the block returns one write strobe and one data word for each destination.

A per-bus connectivity table, fixed by parameters, decides which bus may read which source and write which destination. A move that needs a pair the table does not provide is dropped and reported. A guard selector of zero makes the move unconditional. Any other value picks one of seven boolean guard inputs, and a zero guard cancels the move. When two live moves aim at the same destination, the lowest-numbered bus wins and a conflict pulse is raised. A result can be moved straight from one unit's result port into another unit's operand port, bypassing the register file. The number of register file read and write ports is set apart from the number of buses.

Top module: `tta_move_xbar`

## Requirements
- R1: Bus b takes bits [27*b+26 : 27*b] of the instruction word. Inside a slot: bit 26 enables the move, bits 25:23 are the guard selector, bits 22:17 the destination address, bit 16 selects an immediate source (1) or a port source (0), and bits 15:0 hold the immediate, or the source address in bits 5:0.
- R2: A move presented with `instr_valid_i` high appears on `dst_we_o` and `dst_data_o` after the next rising clock edge, for exactly one cycle. With `instr_valid_i` low, no strobe and no flag follows.
- R3: Moves on different buses to different destinations all complete in the same cycle.
- R4: A move whose guard selector g is 1 to 7 is cancelled when `guard_i[g-1]` is 0. Its destination sees no write, and no flag is raised for it.
- R5: A move whose guard selector is 0 is performed whatever `guard_i` holds.
- R6: An immediate source is sign-extended from 16 to 32 bits.
- R7: Source addresses 0-3 are register file read ports and 4-7 are function unit result ports. Destination addresses 0-3 are register file write ports and 4-7 are function unit operand ports. Any connected source may go to any connected destination, including result to operand.
- R8: A guard-passing move that uses a source or destination its bus is not connected to, or an address of 8 or above, writes nothing and pulses `unconn_o` one cycle later. By default bus 2 cannot read source 7 and cannot write destination 0.
- R9: When two or more live moves name the same destination, only the lowest-numbered bus writes it, and `conflict_o` pulses one cycle later. Cancelled or dropped moves take no part in this.
- R10: A destination's data output holds its last written value until it is written again.
- R11: During reset all strobes and flags are low and all destination data words are zero.
- R12: A slot whose enable bit is 0 writes nothing and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 81 | Three move slots, bus 0 in the low bits |
| src_data_i | input | 256 | Output port values, port s in bits [32*s+31:32*s] |
| guard_i | input | 7 | Guard registers 1 to 7, register g in bit g-1 |
| dst_we_o | output | 8 | Write strobe per destination port |
| dst_data_o | output | 256 | Data per destination port, port d in bits [32*d+31:32*d] |
| conflict_o | output | 1 | Two live moves named one destination |
| unconn_o | output | 1 | A move needed a missing connection |

## Verification
The properties assume that `src_data_i` and `guard_i` are settled for the whole cycle in which the instruction word is valid, since the guard is judged in that cycle and not the next. They also assume that the instruction word changes only between edges. The stimulus drives every input on the falling edge and holds it through the rising edge that takes it. It drops `instr_valid_i` right after each sample, so every idle cycle really is idle.

// File: rtl/tta_move_pkg.sv
package tta_move_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int ADDR_W = 6;
    localparam int GSEL_W = 3;
    localparam int SLOT_W = 1 + GSEL_W + ADDR_W + 1 + IMM_W;

    // Encoded slot as it sits in the instruction word (MSB first).
    typedef struct packed {
        logic              en;
        logic [GSEL_W-1:0] gsel;
        logic [ADDR_W-1:0] dst;
        logic              is_imm;
        logic [IMM_W-1:0]  field;
    } slot_t;

    // Decoded move, one per bus.
    typedef struct packed {
        logic              en;
        logic [GSEL_W-1:0] gsel;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
        logic              is_imm;
        logic [DATA_W-1:0] imm;
    } move_t;

    // What a bus actually carries after guard and socket checks.
    typedef struct packed {
        logic              live;
        logic              unconn;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } xfer_t;

endpackage

// File: rtl/tta_slot_decode.sv
module tta_slot_decode
    import tta_move_pkg::*;
(
    input  logic  valid_i,
    input  slot_t slot_i,
    output move_t move_o
);

    always_comb begin
        move_o.en     = valid_i && slot_i.en;
        move_o.gsel   = slot_i.gsel;
        move_o.dst    = slot_i.dst;
        move_o.is_imm = slot_i.is_imm;
        move_o.src    = slot_i.field[ADDR_W-1:0];
        move_o.imm    = {{(DATA_W-IMM_W){slot_i.field[IMM_W-1]}}, slot_i.field};
    end

endmodule

// File: rtl/tta_bus_lane.sv
module tta_bus_lane
    import tta_move_pkg::*;
#(
    parameter int                 NUM_SRC   = 8,
    parameter int                 NUM_DST   = 8,
    parameter int                 NUM_GUARD = 7,
    parameter logic [NUM_SRC-1:0] SRC_ROW   = '1,
    parameter logic [NUM_DST-1:0] DST_ROW   = '1
)(
    input  move_t                           move_i,
    input  logic [NUM_SRC-1:0][DATA_W-1:0]  src_i,
    input  logic [NUM_GUARD-1:0]            guard_i,
    output xfer_t                           xfer_o
);

    logic              guard_ok;
    logic              src_ok;
    logic              dst_ok;
    logic [DATA_W-1:0] src_val;

    // Guard evaluation: selector 0 means unconditional.
    always_comb begin
        guard_ok = 1'b1;
        if (move_i.gsel != '0) begin
            guard_ok = 1'b0;
            for (int g = 0; g < NUM_GUARD; g++) begin
                if (move_i.gsel == GSEL_W'(g + 1)) guard_ok = guard_i[g];
            end
        end
    end

    // Source socket: immediates need no connection.
    always_comb begin
        src_ok  = move_i.is_imm;
        src_val = move_i.imm;
        if (!move_i.is_imm) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (move_i.src == ADDR_W'(s)) begin
                    src_ok  = SRC_ROW[s];
                    src_val = src_i[s];
                end
            end
        end
    end

    // Destination socket.
    always_comb begin
        dst_ok = 1'b0;
        for (int d = 0; d < NUM_DST; d++) begin
            if (move_i.dst == ADDR_W'(d)) dst_ok = DST_ROW[d];
        end
    end

    always_comb begin
        xfer_o.live   = move_i.en && guard_ok && src_ok && dst_ok;
        xfer_o.unconn = move_i.en && guard_ok && !(src_ok && dst_ok);
        xfer_o.dst    = move_i.dst;
        xfer_o.data   = src_val;
    end

endmodule

// File: rtl/tta_dst_merge.sv
module tta_dst_merge
    import tta_move_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int NUM_DST = 8
)(
    input  xfer_t [NUM_BUS-1:0]             xfer_i,
    output logic  [NUM_DST-1:0]             we_o,
    output logic  [NUM_DST-1:0][DATA_W-1:0] data_o,
    output logic                            conflict_o
);

    // Per destination, scan buses from 0 upward; the first live hit wins.
    always_comb begin
        we_o       = '0;
        data_o     = '0;
        conflict_o = 1'b0;
        for (int d = 0; d < NUM_DST; d++) begin
            for (int b = 0; b < NUM_BUS; b++) begin
                if (xfer_i[b].live && xfer_i[b].dst == ADDR_W'(d)) begin
                    if (we_o[d]) begin
                        conflict_o = 1'b1;
                    end else begin
                        we_o[d]   = 1'b1;
                        data_o[d] = xfer_i[b].data;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tta_move_xbar.sv
module tta_move_xbar
    import tta_move_pkg::*;
#(
    parameter int NUM_BUS      = 3,
    parameter int RF_RD_PORTS  = 4,
    parameter int FU_RES_PORTS = 4,
    parameter int RF_WR_PORTS  = 4,
    parameter int FU_IN_PORTS  = 4,
    parameter int NUM_SRC      = RF_RD_PORTS + FU_RES_PORTS,
    parameter int NUM_DST      = RF_WR_PORTS + FU_IN_PORTS,
    parameter logic [NUM_BUS*NUM_SRC-1:0] SRC_CONN = 24'h7F_FFFF,
    parameter logic [NUM_BUS*NUM_DST-1:0] DST_CONN = 24'hFE_FFFF
)(
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       instr_valid_i,
    input  logic [NUM_BUS*SLOT_W-1:0]  instr_i,
    input  logic [NUM_SRC*DATA_W-1:0]  src_data_i,
    input  logic [(2**GSEL_W)-2:0]     guard_i,
    output logic [NUM_DST-1:0]         dst_we_o,
    output logic [NUM_DST*DATA_W-1:0]  dst_data_o,
    output logic                       conflict_o,
    output logic                       unconn_o
);

    localparam int NUM_GUARD = (2**GSEL_W) - 1;

    typedef struct packed {
        logic [NUM_DST-1:0]             we;
        logic [NUM_DST-1:0][DATA_W-1:0] data;
        logic                           conflict;
        logic                           unconn;
    } state_t;

    state_t state_d, state_q;

    logic  [NUM_SRC-1:0][DATA_W-1:0] src_arr;
    move_t [NUM_BUS-1:0]             moves;
    xfer_t [NUM_BUS-1:0]             xfers;
    logic  [NUM_BUS-1:0]             unconn_bus;
    logic  [NUM_DST-1:0]             merge_we;
    logic  [NUM_DST-1:0][DATA_W-1:0] merge_data;
    logic                            merge_conflict;

    assign src_arr = src_data_i;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        tta_slot_decode u_dec (
            .valid_i (instr_valid_i),
            .slot_i  (slot_t'(instr_i[b*SLOT_W +: SLOT_W])),
            .move_o  (moves[b])
        );

        tta_bus_lane #(
            .NUM_SRC   (NUM_SRC),
            .NUM_DST   (NUM_DST),
            .NUM_GUARD (NUM_GUARD),
            .SRC_ROW   (SRC_CONN[b*NUM_SRC +: NUM_SRC]),
            .DST_ROW   (DST_CONN[b*NUM_DST +: NUM_DST])
        ) u_lane (
            .move_i  (moves[b]),
            .src_i   (src_arr),
            .guard_i (guard_i),
            .xfer_o  (xfers[b])
        );

        assign unconn_bus[b] = xfers[b].unconn;
    end

    tta_dst_merge #(
        .NUM_BUS (NUM_BUS),
        .NUM_DST (NUM_DST)
    ) u_merge (
        .xfer_i     (xfers),
        .we_o       (merge_we),
        .data_o     (merge_data),
        .conflict_o (merge_conflict)
    );

    always_comb begin
        state_d          = state_q;
        state_d.we       = merge_we;
        state_d.conflict = merge_conflict;
        state_d.unconn   = |unconn_bus;
        for (int d = 0; d < NUM_DST; d++) begin
            if (merge_we[d]) state_d.data[d] = merge_data[d];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign dst_we_o   = state_q.we;
    assign dst_data_o = state_q.data;
    assign conflict_o = state_q.conflict;
    assign unconn_o   = state_q.unconn;

endmodule

// File: rtl/tta_move_xbar_chk.sv
module tta_move_xbar_chk
    import tta_move_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int NUM_DST = 8
)(
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      instr_valid_i,
    input logic [NUM_BUS*SLOT_W-1:0] instr_i,
    input logic [(2**GSEL_W)-2:0]    guard_i,
    input logic [NUM_DST-1:0]        dst_we_o,
    input logic [NUM_DST*DATA_W-1:0] dst_data_o,
    input logic                      conflict_o,
    input logic                      unconn_o
);

    logic all_guarded;
    logic none_enabled;

    always_comb begin
        all_guarded  = 1'b1;
        none_enabled = 1'b1;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (instr_i[b*SLOT_W + SLOT_W - 1]) none_enabled = 1'b0;
            if (instr_i[b*SLOT_W + SLOT_W - 2 -: GSEL_W] == '0) all_guarded = 1'b0;
        end
    end

    assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !instr_valid_i |=> (dst_we_o == '0 && !conflict_o && !unconn_o));

    assert_write_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(dst_we_o) <= NUM_BUS);

    assert_all_squashed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && guard_i == '0 && all_guarded)
        |=> (dst_we_o == '0 && !conflict_o && !unconn_o));

    assert_conflict_loses_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conflict_o |-> $countones(dst_we_o) < NUM_BUS);

    assert_data_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dst_we_o == '0) |-> $stable(dst_data_o));

    assert_disabled_slots_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && none_enabled)
        |=> (dst_we_o == '0 && !conflict_o && !unconn_o));

endmodule

bind tta_move_xbar tta_move_xbar_chk #(
    .NUM_BUS (NUM_BUS),
    .NUM_DST (NUM_DST)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .guard_i       (guard_i),
    .dst_we_o      (dst_we_o),
    .dst_data_o    (dst_data_o),
    .conflict_o    (conflict_o),
    .unconn_o      (unconn_o)
);

// File: tb/tb_tta_move_xbar.sv
module tb_tta_move_xbar;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic [80:0]  instr = '0;
    logic [255:0] src_data = '0;
    logic [6:0]   guard = '0;
    logic [7:0]   we;
    logic [255:0] data;
    logic         conflict;
    logic         unconn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tta_move_xbar dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .instr_valid_i (valid),
        .instr_i       (instr),
        .src_data_i    (src_data),
        .guard_i       (guard),
        .dst_we_o      (we),
        .dst_data_o    (data),
        .conflict_o    (conflict),
        .unconn_o      (unconn)
    );

    function automatic logic [31:0] sv(int s);
        return 32'hC0DE_0000 + s * 32'h111;
    endfunction

    function automatic logic [26:0] mk(logic en, logic [2:0] g, logic [5:0] d,
                                       logic im, logic [15:0] f);
        return {en, g, d, im, f};
    endfunction

    function automatic logic [31:0] dout(int d);
        return data[d*32 +: 32];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one instruction on the falling edge, sample just after the rising edge.
    task automatic step(logic [80:0] ins, logic v, logic [6:0] g);
        @(negedge clk);
        instr = ins;
        valid = v;
        guard = g;
        @(posedge clk);
        #1;
        valid = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R11 we in reset", 32'(we), 32'h0);
        chk("R11 data in reset", 32'(|data), 32'h0);
        chk("R11 flags in reset", 32'({conflict, unconn}), 32'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_single();
        @(negedge clk);
        instr = {27'h0, 27'h0, mk(1, 0, 1, 0, 16'd3)};
        valid = 1'b1;
        #1;
        chk("R2 no write before edge", 32'(we), 32'h0);
        @(posedge clk); #1;
        valid = 1'b0;
        chk("R1 R7 rf read to rf write strobe", 32'(we), 32'h02);
        chk("R7 rf read data", dout(1), sv(3));
        @(posedge clk); #1;
        chk("R2 strobe lasts one cycle", 32'(we), 32'h0);
    endtask

    task automatic t_parallel();
        step({mk(1, 0, 6, 1, 16'h1234), mk(1, 0, 4, 0, 16'd5), mk(1, 0, 0, 0, 16'd2)}, 1, 0);
        chk("R3 three strobes", 32'(we), 32'h51);
        chk("R3 bus0 data", dout(0), sv(2));
        chk("R3 bus1 data", dout(4), sv(5));
        chk("R3 bus2 data", dout(6), 32'h0000_1234);
    endtask

    task automatic t_guard();
        step({27'h0, 27'h0, mk(1, 0, 3, 1, 16'h0AAA)}, 1, 0);
        chk("R5 preload dst3", dout(3), 32'h0000_0AAA);
        step({mk(1, 0, 5, 0, 16'd1), mk(1, 2, 3, 0, 16'd6), mk(1, 1, 2, 0, 16'd0)}, 1, 7'b000_0101);
        chk("R4 R5 strobes", 32'(we), 32'h24);
        chk("R4 squashed dst keeps value", dout(3), 32'h0000_0AAA);
        chk("R4 no flags for squash", 32'({conflict, unconn}), 32'h0);
        chk("R4 passing guard data", dout(2), sv(0));
        chk("R5 unguarded data", dout(5), sv(1));
        step({27'h0, 27'h0, mk(1, 7, 7, 1, 16'h0077)}, 1, 7'b100_0000);
        chk("R4 guard 7 passes", dout(7), 32'h0000_0077);
        step({27'h0, 27'h0, mk(1, 0, 7, 1, 16'h0055)}, 1, 7'b000_0000);
        chk("R5 unguarded with zero guards", 32'(we), 32'h80);
    endtask

    task automatic t_imm();
        step({27'h0, mk(1, 0, 7, 1, 16'h8001), mk(1, 0, 3, 1, 16'h7FFF)}, 1, 0);
        chk("R6 negative immediate", dout(7), 32'hFFFF_8001);
        chk("R6 positive immediate", dout(3), 32'h0000_7FFF);
    endtask

    task automatic t_bypass();
        step({27'h0, mk(1, 0, 4, 0, 16'd7), mk(1, 0, 5, 0, 16'd4)}, 1, 0);
        chk("R7 bypass strobes", 32'(we), 32'h30);
        chk("R7 fu result to fu operand", dout(5), sv(4));
        chk("R7 bus1 reads source 7", dout(4), sv(7));
    endtask

    task automatic t_unconn();
        step({mk(1, 0, 6, 0, 16'd7), 27'h0, mk(1, 0, 1, 1, 16'h0042)}, 1, 0);
        chk("R8 missing source strobes", 32'(we), 32'h02);
        chk("R8 missing source flag", 32'(unconn), 32'h1);
        step({mk(1, 0, 0, 1, 16'h0099), 27'h0, 27'h0}, 1, 0);
        chk("R8 missing destination strobes", 32'(we), 32'h0);
        chk("R8 missing destination flag", 32'(unconn), 32'h1);
        step({27'h0, mk(1, 0, 9, 1, 16'h0001), 27'h0}, 1, 0);
        chk("R8 out of range destination", 32'({we, unconn}), 32'h1);
        step({mk(1, 2, 6, 0, 16'd7), 27'h0, 27'h0}, 1, 0);
        chk("R8 squashed move raises no flag", 32'(unconn), 32'h0);
    endtask

    task automatic t_conflict();
        step({mk(1, 0, 2, 1, 16'h0022), mk(1, 0, 3, 1, 16'h0033), mk(1, 0, 2, 1, 16'h0011)}, 1, 0);
        chk("R9 strobes", 32'(we), 32'h0C);
        chk("R9 lowest bus wins", dout(2), 32'h0000_0011);
        chk("R9 flag", 32'(conflict), 32'h1);
        step({27'h0, mk(1, 2, 2, 1, 16'h0044), mk(1, 0, 2, 1, 16'h0012)}, 1, 0);
        chk("R9 squashed move no conflict", 32'(conflict), 32'h0);
        chk("R9 survivor data", dout(2), 32'h0000_0012);
    endtask

    task automatic t_hold();
        step({mk(1, 0, 2, 1, 16'h0BAD), 27'h0, 27'h0}, 0, 0);
        chk("R2 invalid word no strobe", 32'(we), 32'h0);
        chk("R10 dst2 holds", dout(2), 32'h0000_0012);
        chk("R10 dst5 holds", dout(5), sv(4));
    endtask

    task automatic t_disabled();
        step({mk(0, 0, 1, 1, 16'h0BAD), mk(0, 0, 1, 1, 16'h0BAD), mk(0, 0, 0, 0, 16'd9)}, 1, 0);
        chk("R12 no strobe", 32'(we), 32'h0);
        chk("R12 no flags", 32'({conflict, unconn}), 32'h0);
        chk("R12 dst1 unchanged", dout(1), 32'h0000_0042);
    endtask

    initial begin
        for (int s = 0; s < 8; s++) src_data[s*32 +: 32] = sv(s);
        t_reset();
        t_single();
        t_parallel();
        t_guard();
        t_imm();
        t_bypass();
        t_unconn();
        t_conflict();
        t_hold();
        t_disabled();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule